// File: doc/BRIEF.md
# Link Bring-Up Reset Sequencer

This controller brings an Ethernet MAC/PCS subsystem out of reset after power-on, or whenever a start request is given. It drives an active-low global reset into the subsystem and holds it low until two things are true: a minimum hold time has passed, and the subsystem has lowered its active-low reset acknowledge. It then releases the reset. Next it waits for the transmit lanes to report stable. Only after that does it wait for the receive PCS to report ready. When both are ready it raises a link-up flag, which downstream logic uses to enable packet generation.

Each waiting phase is bounded by a cycle timeout. When a timeout expires, the sequencer sets a sticky error flag, drives the reset low again and parks in idle until the next start request. If either readiness indication drops while the link is up, link-up clears and the sequence restarts from the reset phase. The acknowledge and both readiness inputs come from another clock domain, so each one passes through a flop synchronizer before the control logic uses it.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start request, `glob_rst_n`, `link_up` and `tmo_err` are all 0. The acknowledge and readiness inputs alone never start a sequence.
- R2: A start request drives `glob_rst_n` to 0. It stays 0 for at least MIN_RST_CYC cycles, and until the synchronized `rst_ack_n` is 0, whichever comes later.
- R3: After `glob_rst_n` rises, the sequencer waits for the synchronized `tx_lanes_ok` to be 1. A high `rx_pcs_ok` in this phase has no effect, and `link_up` stays 0.
- R4: Once TX is stable, the sequencer waits for the synchronized `rx_pcs_ok` to be 1. `link_up` rises one cycle after the TX-stable state is taken, if RX is already ready.
- R5: `link_up` is 1 only while `glob_rst_n` is 1. If either synchronized readiness input is 0 while the link is up, `link_up` falls and `glob_rst_n` is driven to 0, which restarts the reset phase.
- R6: If any waiting phase (reset hold, TX wait or RX wait) lasts WAIT_LIMIT cycles without its condition being met, `tmo_err` is set and the sequencer returns to idle with `glob_rst_n` at 0 and `link_up` at 0.
- R7: `tmo_err` stays 1 until a start request is sampled. It is 0 from the cycle after that request.
- R8: A start request sampled in any state forces the reset phase, with a fresh hold count. In the next cycle `glob_rst_n` and `link_up` are 0.
- R9: `rst_ack_n`, `tx_lanes_ok` and `rx_pcs_ok` each pass through SYNC_STAGES flops before use. Their reset values are 1 for the acknowledge and 0 for the readiness inputs. A change therefore reaches the control logic SYNC_STAGES cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Start or restart request, sampled every cycle |
| rst_ack_n | input | 1 | Active-low reset acknowledge from the subsystem |
| tx_lanes_ok | input | 1 | High when the transmit lanes are stable |
| rx_pcs_ok | input | 1 | High when the receive PCS is ready |
| glob_rst_n | output | 1 | Active-low global reset to the subsystem |
| link_up | output | 1 | High when bring-up has finished; enables traffic |
| tmo_err | output | 1 | Sticky timeout error |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_RST_CYC=4 and WAIT_LIMIT=20. The short limit lets each of the three timeouts expire within a few dozen cycles. The small hold count lets an early acknowledge show that the minimum hold governs release, while a late acknowledge shows that the acknowledge governs release. With two synchronizer stages, the bench can observe the exact cycles of latency between a readiness edge and link-up. It can also observe restarts issued in the middle of the TX wait and while the link is up.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RST_HOLD = 3'd1,
    ST_WAIT_TX  = 3'd2,
    ST_WAIT_RX  = 3'd3,
    ST_LINK_UP  = 3'd4
  } lbs_state_e;

  localparam int unsigned LBS_N_SYNC = 3;

endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      logic unused_sync_pins;
      assign unused_sync_pins = clk ^ rst_n;
      assign d_out = d_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
          chain_d[i] = chain_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= {STAGES{RST_VAL}};
        end else begin
          chain_q <= chain_d;
        end
      end

      assign d_out = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
  parameter int unsigned LIMIT    = 4096,
  parameter int unsigned MIN_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic min_met_o,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(LIMIT) + 1;
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] MIN_VAL  = CNT_W'(MIN_HOLD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Counts cycles in the current state, saturating at the limit
  always_comb begin
    cnt_en = clr_i || (cnt_q != LAST_VAL);
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign min_met_o = (cnt_q >= MIN_VAL);
  assign expired_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/lbs_ctrl_fsm.sv
module lbs_ctrl_fsm
  import lbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_n_i,
  input  logic tx_ok_i,
  input  logic rx_ok_i,
  input  logic min_met_i,
  input  logic expired_i,
  output logic tmr_clr_o,
  output logic glob_rst_n_o,
  output logic link_up_o,
  output logic tmo_err_o
);

  lbs_state_e state_q, state_d;
  logic       tmo_fire;
  logic       rel_q, rel_d;
  logic       up_q, up_d;
  logic       err_q, err_d, err_en;

  always_comb begin
    state_d  = state_q;
    tmo_fire = 1'b0;
    if (start_i) begin
      state_d = ST_RST_HOLD;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_RST_HOLD: begin
          if (min_met_i && !ack_n_i) begin
            state_d = ST_WAIT_TX;
          end else if (expired_i) begin
            state_d  = ST_IDLE;
            tmo_fire = 1'b1;
          end
        end
        ST_WAIT_TX: begin
          if (tx_ok_i) begin
            state_d = ST_WAIT_RX;
          end else if (expired_i) begin
            state_d  = ST_IDLE;
            tmo_fire = 1'b1;
          end
        end
        ST_WAIT_RX: begin
          if (rx_ok_i) begin
            state_d = ST_LINK_UP;
          end else if (expired_i) begin
            state_d  = ST_IDLE;
            tmo_fire = 1'b1;
          end
        end
        ST_LINK_UP: begin
          if (!tx_ok_i || !rx_ok_i) begin
            state_d = ST_RST_HOLD;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_clr_o = start_i || (state_d != state_q);
    rel_d     = (state_d inside {ST_WAIT_TX, ST_WAIT_RX, ST_LINK_UP});
    up_d      = (state_d == ST_LINK_UP);
    err_en    = start_i || tmo_fire;
    err_d     = !start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rel_q   <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
      up_q    <= up_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign glob_rst_n_o = rel_q;
  assign link_up_o    = up_q;
  assign tmo_err_o    = err_q;

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_RST_CYC = 16,
  parameter int unsigned WAIT_LIMIT  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic rst_ack_n,
  input  logic tx_lanes_ok,
  input  logic rx_pcs_ok,
  output logic glob_rst_n,
  output logic link_up,
  output logic tmo_err
);

  // Bit order of the synchronizer bank: 0 ack, 1 tx, 2 rx
  localparam logic [LBS_N_SYNC-1:0] SYNC_RST = 3'b001;

  logic [LBS_N_SYNC-1:0] raw_in;
  logic [LBS_N_SYNC-1:0] syn_in;
  logic                  tmr_clr;
  logic                  min_met;
  logic                  expired;

  assign raw_in = {rx_pcs_ok, tx_lanes_ok, rst_ack_n};

  for (genvar gi = 0; gi < LBS_N_SYNC; gi++) begin : g_sync
    lbs_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST[gi])
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in[gi]),
      .d_out (syn_in[gi])
    );
  end

  lbs_wait_timer #(
    .LIMIT    (WAIT_LIMIT),
    .MIN_HOLD (MIN_RST_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .min_met_o (min_met),
    .expired_o (expired)
  );

  lbs_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_req),
    .ack_n_i      (syn_in[0]),
    .tx_ok_i      (syn_in[1]),
    .rx_ok_i      (syn_in[2]),
    .min_met_i    (min_met),
    .expired_i    (expired),
    .tmr_clr_o    (tmr_clr),
    .glob_rst_n_o (glob_rst_n),
    .link_up_o    (link_up),
    .tmo_err_o    (tmo_err)
  );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int unsigned MIN_RST_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic glob_rst_n,
  input logic link_up,
  input logic tmo_err
);

  localparam int unsigned LC_W = $clog2(MIN_RST_CYC + 1) + 1;
  localparam logic [LC_W-1:0] LC_MAX = LC_W'(MIN_RST_CYC);

  logic [LC_W-1:0] low_cnt;

  // Counts the cycles glob_rst_n has been sampled low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (glob_rst_n) begin
      low_cnt <= '0;
    end else if (low_cnt != LC_MAX) begin
      low_cnt <= low_cnt + LC_W'(1);
    end
  end

  p_min_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glob_rst_n) |-> (low_cnt >= LC_MAX));

  p_up_needs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> glob_rst_n);

  p_err_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> (!glob_rst_n && !link_up));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !start_req) |=> tmo_err);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !tmo_err);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (!glob_rst_n && !link_up));

endmodule

bind link_bringup_seq lbs_checker #(
  .MIN_RST_CYC (MIN_RST_CYC)
) u_lbs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .glob_rst_n (glob_rst_n),
  .link_up    (link_up),
  .tmo_err    (tmo_err)
);

// File: tb/link_bringup_seq_tb_top.sv
module link_bringup_seq_tb_top;

  localparam int TB_SYNC = 2;
  localparam int TB_MIN  = 4;
  localparam int TB_LIM  = 20;

  localparam int M_IDLE = 0, M_RST = 1, M_WTX = 2, M_WRX = 3, M_UP = 4;

  logic clk, rst_n, start_req, rst_ack_n, tx_lanes_ok, rx_pcs_ok;
  logic glob_rst_n, link_up, tmo_err;

  int    vecs;
  int    miss;
  bit    cmp_en;
  string cur_req;

  link_bringup_seq #(
    .SYNC_STAGES (TB_SYNC),
    .MIN_RST_CYC (TB_MIN),
    .WAIT_LIMIT  (TB_LIM)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .rst_ack_n   (rst_ack_n),
    .tx_lanes_ok (tx_lanes_ok),
    .rx_pcs_ok   (rx_pcs_ok),
    .glob_rst_n  (glob_rst_n),
    .link_up     (link_up),
    .tmo_err     (tmo_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: queues for the synchronizers, an integer phase
  bit qa[$], qt[$], qr[$];
  int m_st, m_cnt;
  bit m_rel, m_up, m_err;

  always @(posedge clk or negedge rst_n) begin : ref_model
    bit a, t, r;
    int nst;
    if (!rst_n) begin
      m_st = M_IDLE; m_cnt = 0; m_rel = 0; m_up = 0; m_err = 0;
      qa.delete(); qt.delete(); qr.delete();
      for (int i = 0; i < TB_SYNC; i++) begin
        qa.push_back(1'b1); qt.push_back(1'b0); qr.push_back(1'b0);
      end
    end else begin
      a = qa.pop_front(); t = qt.pop_front(); r = qr.pop_front();
      qa.push_back(rst_ack_n); qt.push_back(tx_lanes_ok); qr.push_back(rx_pcs_ok);
      nst = m_st;
      if (start_req) begin
        nst = M_RST;
        m_err = 0;
      end else if (m_st == M_RST) begin
        if (m_cnt >= TB_MIN - 1 && !a) nst = M_WTX;
        else if (m_cnt == TB_LIM - 1) begin nst = M_IDLE; m_err = 1; end
      end else if (m_st == M_WTX) begin
        if (t) nst = M_WRX;
        else if (m_cnt == TB_LIM - 1) begin nst = M_IDLE; m_err = 1; end
      end else if (m_st == M_WRX) begin
        if (r) nst = M_UP;
        else if (m_cnt == TB_LIM - 1) begin nst = M_IDLE; m_err = 1; end
      end else if (m_st == M_UP) begin
        if (!t || !r) nst = M_RST;
      end
      if (start_req || nst != m_st) m_cnt = 0;
      else if (m_cnt < TB_LIM - 1) m_cnt = m_cnt + 1;
      m_st  = nst;
      m_rel = (nst == M_WTX) || (nst == M_WRX) || (nst == M_UP);
      m_up  = (nst == M_UP);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      vecs++;
      if (glob_rst_n !== m_rel || link_up !== m_up || tmo_err !== m_err) begin
        miss++;
        $display("FAIL %s cycle compare: got rst_n=%0b up=%0b err=%0b, expected %0b %0b %0b",
                 cur_req, glob_rst_n, link_up, tmo_err, m_rel, m_up, m_err);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit e_rel, input bit e_up, input bit e_err);
    vecs++;
    if (glob_rst_n !== e_rel || link_up !== e_up || tmo_err !== e_err) begin
      miss++;
      $display("FAIL %s: got rst_n=%0b up=%0b err=%0b, expected %0b %0b %0b",
               req, glob_rst_n, link_up, tmo_err, e_rel, e_up, e_err);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin : main
    vecs = 0; miss = 0; cmp_en = 0; cur_req = "R1";
    rst_n = 1'b0; start_req = 1'b0; rst_ack_n = 1'b0; tx_lanes_ok = 1'b1; rx_pcs_ok = 1'b1;
    cyc(3);
    expect_out("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    // R1: inputs all favourable, but no start request
    cyc(10);
    expect_out("R1 idle without start", 0, 0, 0);

    // R2/R3/R4/R9: early ack, rx high before tx
    cur_req = "R3"; tx_lanes_ok = 1'b0;
    cyc(3);
    pulse_start();
    cyc(3);
    expect_out("R2 min hold despite early ack", 0, 0, 0);
    cyc(7);
    expect_out("R3 released, rx ignored until tx", 1, 0, 0);
    cur_req = "R9"; tx_lanes_ok = 1'b1;
    cyc(3);
    expect_out("R9 sync latency, not up yet", 1, 0, 0);
    cyc(1);
    expect_out("R4 link up after tx then rx", 1, 1, 0);

    // R5: readiness drop while up
    cur_req = "R5"; rx_pcs_ok = 1'b0;
    cyc(4);
    expect_out("R5 drop restarts reset", 0, 0, 0);
    rx_pcs_ok = 1'b1;
    cyc(20);
    expect_out("R5 link recovers", 1, 1, 0);

    // R8: restart while up
    cur_req = "R8";
    pulse_start();
    expect_out("R8 start while up", 0, 0, 0);
    cyc(15);
    expect_out("R8 up again", 1, 1, 0);

    // R6/R7: ack never arrives
    cur_req = "R6"; rst_ack_n = 1'b1;
    pulse_start();
    cyc(TB_LIM + 4);
    expect_out("R6 ack timeout", 0, 0, 1);
    cur_req = "R7";
    cyc(30);
    expect_out("R7 error sticky", 0, 0, 1);
    rst_ack_n = 1'b0;
    cyc(3);
    pulse_start();
    expect_out("R7 start clears error", 0, 0, 0);
    cyc(15);
    expect_out("R7 up after clear", 1, 1, 0);

    // R2: late ack governs release
    cur_req = "R2"; rst_ack_n = 1'b1;
    pulse_start();
    cyc(10);
    expect_out("R2 held for late ack", 0, 0, 0);
    rst_ack_n = 1'b0;
    cyc(15);
    expect_out("R2 released after ack", 1, 1, 0);

    // R6: TX wait timeout
    cur_req = "R6"; tx_lanes_ok = 1'b0;
    cyc(40);
    expect_out("R6 tx timeout", 0, 0, 1);

    // R8: restart inside the TX wait
    cur_req = "R8";
    pulse_start();
    cyc(8);
    expect_out("R3 waiting for tx", 1, 0, 0);
    pulse_start();
    expect_out("R8 start during tx wait", 0, 0, 0);

    // R6: RX wait timeout
    cur_req = "R6"; tx_lanes_ok = 1'b1; rx_pcs_ok = 1'b0;
    cyc(40);
    expect_out("R6 rx timeout", 0, 0, 1);

    cur_req = "R4"; rx_pcs_ok = 1'b1;
    pulse_start();
    cyc(15);
    expect_out("R4 final bring-up", 1, 1, 0);

    cmp_en = 0;
    summary();
    $finish;
  end

endmodule